// File: doc/BRIEF.md
# Programmable Interrupt Router with Lost-Interrupt Capture

This block sits between a wide field of system event pulses and the twelve maskable interrupt inputs of a processor core, numbered INT4 through INT15. Each interrupt line has its own 7-bit selector. The selector picks any one of the 128 event inputs, and several lines may pick the same event. The selected event pulse comes out on the line one clock later.

The processor reports, per line, whether an interrupt is still pending. If a line's chosen event fires again while that line is still pending, the earlier request is lost. The router then signals an error pulse and captures the number of the first line that lost an interrupt. Software may exclude lines from this check through a mask register. It clears the captured record with a command write.

Configuration goes through a small word-addressed register port. Register reads are returned one clock after the address is presented.

Top module: `irq_route_top`

## Requirements
- R1: After synchronous reset, every selector reads 0 (event 0), the drop mask and drop status read 0, and `int_out` and `drop_evt` are 0.
- R2: Bit i of `int_out` (INT(4+i)) is high in the cycle after the cycle in which the event chosen by line i's selector is high on `evt_in`.
- R3: Word addresses 0, 1 and 2 hold the selectors for INT4–INT7, INT8–INT11 and INT12–INT15, in ascending line order. The fields sit at bits 6:0, 14:8, 22:16 and 30:24. Bits 7, 15, 23 and 31 read back as 0.
- R4: Any event number 0..127 can be chosen for any line, and one event may drive several lines in the same cycle.
- R5: A drop occurs when line i's chosen event is high while `int_pending[i]` is 1 and mask bit i is 0. `drop_evt` is then high for exactly one cycle, in the same cycle that `int_out` shows the event.
- R6: A line with `int_pending` at 0, or with its mask bit set, never causes a drop: `drop_evt` stays 0 and the status record is unchanged.
- R7: The status register at address 3 has a valid flag at bit 8 and the interrupt number (4..15) at bits 3:0. Only the first drop is captured until cleared. Later drops pulse `drop_evt` but leave the record unchanged. When several lines drop in the same cycle, the lowest-numbered line is recorded.
- R8: Writing address 4 with bit 0 set clears the status record, and a write with bit 0 at 0 has no effect. A drop in the same cycle as the clearing write is recorded. Address 4 reads as 0.
- R9: The drop mask at address 5 uses bit position n for INT n (bits 15:4). All other bits read as 0.
- R10: `cfg_rdata` shows the register at `cfg_addr` one cycle after the address is presented. Writes to the status address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data for `cfg_addr` |
| evt_in | input | 128 | System event pulses |
| int_pending | input | 12 | Per-line pending state from the processor (bit 0 = INT4) |
| int_out | output | 12 | Routed interrupt pulses (bit 0 = INT4) |
| drop_evt | output | 1 | One-cycle lost-interrupt error pulse |

## Verification
On every cycle, the assertions check four things. A captured record stays frozen until a clearing write. The recorded number stays within INT4..INT15. Every error pulse is backed by a routed pulse on a line that was pending and unmasked. The mask changes only on a write. The bench scenarios cover what needs known stimulus and expected values: the field layout and the discarded bit positions, many-to-one routing, lowest-line priority when several lines drop at once, the clear-versus-new-drop collision, and the ignored writes to the status and command addresses.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int FIELD_STRIDE  = 8;
  localparam int FIELDS_PER_WD = 4;
  localparam int STAT_VLD_BIT  = 8;

  typedef struct packed {
    logic       vld;
    logic [3:0] num;
  } drop_rec_t;
endpackage

// File: rtl/irq_evt_sel.sv
module irq_evt_sel #(
  parameter int NUM_EVT = 128,
  parameter int SEL_W   = $clog2(NUM_EVT)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               hit_o,
  output logic               int_o
);
  always_comb begin
    hit_o = 1'b0;
    if (int'(sel_i) < NUM_EVT) hit_o = evt_i[sel_i];
  end

  always_ff @(posedge clk) begin
    if (rst) int_o <= 1'b0;
    else     int_o <= hit_o;
  end
endmodule

// File: rtl/irq_drop_detect.sv
module irq_drop_detect #(
  parameter int NUM_INT   = 12,
  parameter int FIRST_INT = 4,
  parameter int NUM_W     = $clog2(FIRST_INT + NUM_INT)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_INT-1:0] hit_i,
  input  logic [NUM_INT-1:0] pend_i,
  input  logic [NUM_INT-1:0] mask_i,
  input  logic               clr_i,
  output logic               drop_o,
  output logic               vld_o,
  output logic [NUM_W-1:0]   num_o
);
  logic [NUM_INT-1:0] drop_vec;
  logic [NUM_W-1:0]   first_num;
  logic               any_drop;

  assign drop_vec = hit_i & pend_i & ~mask_i;
  assign any_drop = |drop_vec;

  always_comb begin
    first_num = '0;
    for (int i = NUM_INT - 1; i >= 0; i--) begin
      if (drop_vec[i]) first_num = NUM_W'(i + FIRST_INT);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drop_o <= 1'b0;
      vld_o  <= 1'b0;
      num_o  <= '0;
    end else begin
      drop_o <= any_drop;
      if (any_drop && (!vld_o || clr_i)) begin
        vld_o <= 1'b1;
        num_o <= first_num;
      end else if (clr_i) begin
        vld_o <= 1'b0;
        num_o <= '0;
      end
    end
  end

  // R7
  rec_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (vld_o && !clr_i) |=> (vld_o && $stable(num_o)));

  // R7
  rec_range_chk: assert property (@(posedge clk) disable iff (rst)
    vld_o |-> (int'(num_o) >= FIRST_INT && int'(num_o) < FIRST_INT + NUM_INT));

  // R5
  drop_rec_chk: assert property (@(posedge clk) disable iff (rst)
    drop_o |-> vld_o);
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_route_pkg::*;
#(
  parameter int NUM_EVT   = 128,
  parameter int NUM_INT   = 12,
  parameter int FIRST_INT = 4,
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 32,
  parameter int SEL_W     = $clog2(NUM_EVT),
  parameter int NUM_W     = $clog2(FIRST_INT + NUM_INT)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic                     st_vld_i,
  input  logic [NUM_W-1:0]         st_num_i,
  output logic [NUM_INT*SEL_W-1:0] sel_o,
  output logic [NUM_INT-1:0]       mask_o,
  output logic                     clr_o,
  output logic [DATA_W-1:0]        rdata_o
);
  localparam int NUM_MUX  = (NUM_INT + FIELDS_PER_WD - 1) / FIELDS_PER_WD;
  localparam int STAT_ADR = NUM_MUX;
  localparam int CLR_ADR  = NUM_MUX + 1;
  localparam int MASK_ADR = NUM_MUX + 2;

  logic [SEL_W-1:0]  sel_q [NUM_INT];
  logic [DATA_W-1:0] rd_word;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign clr_o = wr_i && (int'(addr_i) == CLR_ADR) && wdata_i[0];

  for (genvar i = 0; i < NUM_INT; i++) begin : g_sel
    localparam int WD   = i / FIELDS_PER_WD;
    localparam int SLOT = i % FIELDS_PER_WD;
    always_ff @(posedge clk) begin
      if (rst) sel_q[i] <= '0;
      else if (wr_i && int'(addr_i) == WD)
        sel_q[i] <= wdata_i[SLOT*FIELD_STRIDE +: SEL_W];
    end
    assign sel_o[i*SEL_W +: SEL_W] = sel_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) mask_o <= '0;
    else if (wr_i && int'(addr_i) == MASK_ADR)
      mask_o <= wdata_i[FIRST_INT +: NUM_INT];
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_INT; i++) begin
      if (int'(addr_i) == i / FIELDS_PER_WD)
        rd_word[(i % FIELDS_PER_WD)*FIELD_STRIDE +: SEL_W] = sel_q[i];
    end
    if (int'(addr_i) == STAT_ADR) begin
      rd_word[STAT_VLD_BIT]  = st_vld_i;
      rd_word[NUM_W-1:0]     = st_num_i;
    end
    if (int'(addr_i) == MASK_ADR)
      rd_word[FIRST_INT +: NUM_INT] = mask_o;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_word;
  end

  // R9
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_i |=> $stable(mask_o));
endmodule

// File: rtl/irq_route_top.sv
module irq_route_top #(
  parameter int NUM_EVT   = 128,
  parameter int NUM_INT   = 12,
  parameter int FIRST_INT = 4,
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_wr,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [DATA_W-1:0]  cfg_wdata,
  output logic [DATA_W-1:0]  cfg_rdata,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic [NUM_INT-1:0] int_pending,
  output logic [NUM_INT-1:0] int_out,
  output logic               drop_evt
);
  localparam int SEL_W = $clog2(NUM_EVT);
  localparam int NUM_W = $clog2(FIRST_INT + NUM_INT);

  logic [NUM_INT*SEL_W-1:0] sel_flat;
  logic [NUM_INT-1:0]       drop_mask;
  logic [NUM_INT-1:0]       hit;
  logic                     clr_cmd;
  logic                     st_vld;
  logic [NUM_W-1:0]         st_num;

  irq_cfg_regs #(
    .NUM_EVT(NUM_EVT), .NUM_INT(NUM_INT), .FIRST_INT(FIRST_INT),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W), .NUM_W(NUM_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr_i(cfg_wr), .addr_i(cfg_addr),
    .wdata_i(cfg_wdata), .st_vld_i(st_vld), .st_num_i(st_num),
    .sel_o(sel_flat), .mask_o(drop_mask), .clr_o(clr_cmd),
    .rdata_o(cfg_rdata)
  );

  for (genvar i = 0; i < NUM_INT; i++) begin : g_line
    irq_evt_sel #(.NUM_EVT(NUM_EVT), .SEL_W(SEL_W)) u_sel (
      .clk(clk), .rst(rst), .evt_i(evt_in),
      .sel_i(sel_flat[i*SEL_W +: SEL_W]),
      .hit_o(hit[i]), .int_o(int_out[i])
    );
  end

  irq_drop_detect #(
    .NUM_INT(NUM_INT), .FIRST_INT(FIRST_INT), .NUM_W(NUM_W)
  ) u_drop (
    .clk(clk), .rst(rst), .hit_i(hit), .pend_i(int_pending),
    .mask_i(drop_mask), .clr_i(clr_cmd),
    .drop_o(drop_evt), .vld_o(st_vld), .num_o(st_num)
  );

  // R5 R6
  drop_cause_chk: assert property (@(posedge clk) disable iff (rst)
    drop_evt |-> |(int_out & $past(int_pending & ~drop_mask)));
endmodule

// File: tb/test_irq_route_top.sv
module test_irq_route_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cfg_wr = 1'b0;
  logic [2:0]   cfg_addr = '0;
  logic [31:0]  cfg_wdata = '0;
  logic [31:0]  cfg_rdata;
  logic [127:0] evt_in = '0;
  logic [11:0]  int_pending = '0;
  logic [11:0]  int_out;
  logic         drop_evt;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_route_top i_irq_route_top (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .evt_in(evt_in),
    .int_pending(int_pending), .int_out(int_out), .drop_evt(drop_evt)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  // one event pulse; checks routed lines and drop pulse, then the idle cycle
  task automatic fire(input int ev, input logic [11:0] pend,
                      input logic [11:0] exp_int, input logic exp_drop, input string req);
    @(negedge clk);
    evt_in = '0; evt_in[ev] = 1'b1; int_pending = pend;
    @(negedge clk);
    evt_in = '0;
    check(req, 32'(int_out), 32'(exp_int));
    check(req, 32'(drop_evt), 32'(exp_drop));
    @(negedge clk);
    int_pending = '0;
    check(req, 32'(drop_evt), 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1", 32'(int_out), 32'h0);
    check("R1", 32'(drop_evt), 32'h0);
    for (int a = 0; a < 6; a++) begin
      rd_reg(3'(a), d);
      check("R1", d, 32'h0);
    end
  endtask

  task automatic t_layout();
    logic [31:0] d;
    wr_reg(3'd0, 32'hFF858A83);
    rd_reg(3'd0, d);
    check("R3", d, 32'h7F050A03);
    wr_reg(3'd1, 32'h64646464);
    wr_reg(3'd2, 32'h40302010);
    rd_reg(3'd2, d);
    check("R3", d, 32'h40302010);
    rd_reg(3'd1, d);
    check("R10", d, 32'h64646464);
  endtask

  task automatic t_route();
    fire(3,   12'h000, 12'h001, 1'b0, "R2");
    fire(127, 12'h000, 12'h008, 1'b0, "R4");
    fire(100, 12'h000, 12'h0F0, 1'b0, "R4");
    fire(64,  12'h000, 12'h800, 1'b0, "R2");
    fire(0,   12'hFFF, 12'h000, 1'b0, "R2");
  endtask

  task automatic t_no_drop();
    logic [31:0] d;
    fire(32, 12'h000, 12'h200, 1'b0, "R6");
    wr_reg(3'd5, 32'hFFFF8000);
    rd_reg(3'd5, d);
    check("R9", d, 32'h00008000);
    fire(64, 12'hFFF, 12'h800, 1'b0, "R6");
    rd_reg(3'd3, d);
    check("R6", d, 32'h0);
  endtask

  task automatic t_drop();
    logic [31:0] d;
    fire(32, 12'h200, 12'h200, 1'b1, "R5");
    rd_reg(3'd3, d);
    check("R7", d, 32'h10D);
    fire(3, 12'hFFF, 12'h001, 1'b1, "R7");
    rd_reg(3'd3, d);
    check("R7", d, 32'h10D);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr_reg(3'd4, 32'h0);
    rd_reg(3'd3, d);
    check("R8", d, 32'h10D);
    wr_reg(3'd4, 32'h1);
    rd_reg(3'd3, d);
    check("R8", d, 32'h0);
    rd_reg(3'd4, d);
    check("R8", d, 32'h0);
    wr_reg(3'd3, 32'hFFFFFFFF);
    rd_reg(3'd3, d);
    check("R10", d, 32'h0);
    fire(100, 12'hFFF, 12'h0F0, 1'b1, "R7");
    rd_reg(3'd3, d);
    check("R7", d, 32'h108);
    // clear and new drop in the same cycle
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 3'd4; cfg_wdata = 32'h1;
    evt_in = '0; evt_in[3] = 1'b1; int_pending = 12'hFFF;
    @(negedge clk);
    cfg_wr = 1'b0; evt_in = '0; int_pending = '0;
    check("R8", 32'(drop_evt), 32'h1);
    rd_reg(3'd3, d);
    check("R8", d, 32'h104);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_layout();
    t_route();
    t_no_drop();
    t_drop();
    t_clear();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule